// File: doc/BRIEF.md
# Converter parallel host interface

This block sits between a host processor and the conversion core of a data converter. The host shares one 12-bit bidirectional bus with the block and drives chip-select, read and write strobes. A write stores a control word that sets power state, output coding, calibration and the role of a shared pin. A read places the latest conversion result on the bus. Conversion samples come from the core on a simple valid/data port. The block applies the chosen coding and flags each new result with an active-low data-ready line.

Two timed sequences are built in: calibration, started by software, and synchronization, started by a rising edge on the shared pin. Both last a fixed, parameterized number of clocks. During either sequence, data-ready stays inactive and incoming samples are dropped. The shared pin is a data-valid output or a sync input, chosen by a control bit. The bus is split into input, output and output-enable signals, and a pad ring builds the tristate from them.

Top module: `conv_host_if`

## Requirements
- R1: After reset, drdy_n is 1, bus_oe is 0, pin_oe is 1 and pin_out is 0. The control word is all zero: normal power, unipolar coding, data-valid pin mode.
- R2: bus_oe is 1 only while cs_n and rd_n are both 0, and bus_out then carries the latest stored result. When rd_n is 1, or cs_n is 1, the bus is not driven.
- R3: A write takes effect at the end of the write strobe (wr_n rising), after synchronization to clk, with the bus value held since the strobe began. A strobe while cs_n is 1 changes nothing.
- R4: Control bit 2 selects coding. When it is 0 (unipolar), the stored result is the sample with its MSB inverted (offset binary to two's complement). When it is 1 (bipolar), the sample is stored unchanged.
- R5: When a sample is accepted, the result is stored and drdy_n is 1 for that clock. drdy_n falls on the next clock, and the result stays unchanged when drdy_n falls.
- R6: While control bit 0 (standby) is 1, samples are ignored and drdy_n stays 1.
- R7: Writing 1 to control bit 1 starts a calibration of CAL_CYCLES clocks. During calibration, drdy_n is 1 and samples are ignored. The bit then clears by itself, and samples are accepted again with no restart of the calibration.
- R8: When control bit 3 is 0, pin_oe is 1 and pin_out is 1 while a valid result is held. A valid result is cleared by standby, test or the start of a sequence. When bit 3 is 1, pin_oe is 0.
- R9: When control bit 3 is 1, a rising edge on pin_in after at least one clock low starts a synchronization of SYNC_CYCLES clocks, with the same effect on drdy_n and samples as calibration. When bit 3 is 0, edges on pin_in do nothing.
- R10: While control bit 9 (test) is 1, samples are ignored and drdy_n stays 1.
- R11: A sample that arrives in the same clock that a calibration or synchronization starts is dropped. The previous result stays on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe (asynchronous to clk) |
| bus_in | input | 12 | Host bus, input side |
| bus_out | output | 12 | Host bus, output side (result) |
| bus_oe | output | 1 | Host bus output enable |
| pin_in | input | 1 | Shared pin, input side (sync request) |
| pin_out | output | 1 | Shared pin, output side (data valid) |
| pin_oe | output | 1 | Shared pin output enable |
| smp_valid | input | 1 | Sample strobe from the conversion core |
| smp_data | input | 12 | Sample value |
| drdy_n | output | 1 | Active-low data ready |

## Verification
A calibration start, committed at the end of a synchronized write strobe, can fall in the same clock as a sample arriving from the core. The bench counts the synchronizer stages from the release of wr_n. It then raises smp_valid in exactly the clock where the commit lands. The outcome is judged at the ports: drdy_n must stay high through the calibration, and a bus read must still return the result from before the collision. A second sample, sent once calibration has finished, must be accepted normally.

// File: rtl/conv_if_pkg.sv
package conv_if_pkg;

    // control word bit positions
    localparam int unsigned CB_STBY  = 0;
    localparam int unsigned CB_CAL   = 1;
    localparam int unsigned CB_BIP   = 2;
    localparam int unsigned CB_SMODE = 3;
    localparam int unsigned CB_TEST  = 9;

    typedef struct packed {
        logic stby;
        logic bipolar;
        logic sync_mode;
        logic test;
    } ctrl_t;

endpackage

// File: rtl/strobe_sync.sv
// Synchronizes the asynchronous write strobe and chip select, and
// flags the end of a chip-selected strobe.
module strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic cs_n,
    output logic commit
);
    typedef struct packed {
        logic [1:0] wr_s;
        logic [1:0] cs_s;
        logic       wr_prev;
        logic       seen;
    } st_t;

    st_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d         = st_q;
        st_d.wr_s    = {st_q.wr_s[0], wr_n};
        st_d.cs_s    = {st_q.cs_s[0], cs_n};
        st_d.wr_prev = st_q.wr_s[1];
        rise         = st_q.wr_s[1] & ~st_q.wr_prev;
        if (rise) begin
            st_d.seen = 1'b0;
        end else if (!st_q.wr_s[1] && !st_q.cs_s[1]) begin
            st_d.seen = 1'b1;
        end
        commit = rise & st_q.seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wr_s: 2'b11, cs_s: 2'b11, wr_prev: 1'b1, seen: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pin_edge.sv
// Two-flop synchronizer with rising-edge detection. Reset state is high,
// as if pulled up, so no edge appears after reset.
module pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], pin};
        rise = sh_q[1] & ~sh_q[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= 3'b111;
        end else begin
            sh_q <= sh_d;
        end
    end
endmodule

// File: rtl/seq_timer.sv
// Fixed-length busy window, loaded by start.
module seq_timer #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic busy_nx
);
    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
        busy    = (cnt_q != '0);
        busy_nx = (cnt_d != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/conv_host_if.sv
module conv_host_if
    import conv_if_pkg::*;
#(
    parameter int unsigned DW          = 12,
    parameter int unsigned CAL_CYCLES  = 40,
    parameter int unsigned SYNC_CYCLES = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    input  logic          pin_in,
    output logic          pin_out,
    output logic          pin_oe,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    output logic          drdy_n
);
    localparam logic [DW-1:0] SIGN_FLIP = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] result;
        logic          valid;
        logic          drdy_n;
    } st_t;

    st_t  st_d, st_q;
    logic wr_commit, pin_rise;
    logic cal_start, sync_start, seq_start;
    logic cal_busy, cal_busy_nx, sync_busy, sync_busy_nx;
    logic accept;
    logic seq_busy, stby_now, smode_now;

    strobe_sync u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n   (wr_n),
        .cs_n   (cs_n),
        .commit (wr_commit)
    );

    pin_edge u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_in),
        .rise  (pin_rise)
    );

    seq_timer #(.LEN(CAL_CYCLES)) u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cal_start),
        .busy    (cal_busy),
        .busy_nx (cal_busy_nx)
    );

    seq_timer #(.LEN(SYNC_CYCLES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sync_start),
        .busy    (sync_busy),
        .busy_nx (sync_busy_nx)
    );

    always_comb begin
        st_d       = st_q;
        cal_start  = wr_commit & bus_in[CB_CAL];
        sync_start = st_q.ctrl.sync_mode & pin_rise;
        seq_start  = cal_start | sync_start;

        if (wr_commit) begin
            st_d.ctrl.stby      = bus_in[CB_STBY];
            st_d.ctrl.bipolar   = bus_in[CB_BIP];
            st_d.ctrl.sync_mode = bus_in[CB_SMODE];
            st_d.ctrl.test      = bus_in[CB_TEST];
        end

        accept = smp_valid & ~st_q.ctrl.stby & ~st_q.ctrl.test
               & ~cal_busy & ~sync_busy & ~seq_start;

        if (accept) begin
            st_d.result = st_q.ctrl.bipolar ? smp_data : (smp_data ^ SIGN_FLIP);
            st_d.valid  = 1'b1;
        end
        if (seq_start || st_d.ctrl.stby || st_d.ctrl.test) begin
            st_d.valid = 1'b0;
        end

        st_d.drdy_n = accept | ~st_d.valid | st_d.ctrl.stby | st_d.ctrl.test
                    | cal_busy_nx | sync_busy_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: '0, result: '0, valid: 1'b0, drdy_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_oe    = ~cs_n & ~rd_n;
    assign bus_out   = st_q.result;
    assign pin_oe    = ~st_q.ctrl.sync_mode;
    assign pin_out   = st_q.valid & ~st_q.ctrl.sync_mode;
    assign drdy_n    = st_q.drdy_n;
    assign seq_busy  = cal_busy | sync_busy;
    assign stby_now  = st_q.ctrl.stby;
    assign smode_now = st_q.ctrl.sync_mode;
endmodule

// File: rtl/conv_host_if_chk.sv
module conv_host_if_chk #(
    parameter int unsigned DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_n,
    input logic          bus_oe,
    input logic [DW-1:0] bus_out,
    input logic          drdy_n,
    input logic          pin_oe,
    input logic          seq_busy,
    input logic          stby_now,
    input logic          smode_now
);
    // R2: no bus drive while read is inactive
    p_bus_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> !bus_oe);

    // R5: result is steady at the moment data-ready falls
    p_fall_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> $stable(bus_out));

    // R6: standby holds data-ready inactive
    p_stby_drdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stby_now |-> drdy_n);

    // R7 / R9: a running sequence holds data-ready inactive
    p_seq_drdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> drdy_n);

    // R8: sync mode releases the shared pin
    p_pin_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smode_now |-> !pin_oe);
endmodule

bind conv_host_if conv_host_if_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_n      (rd_n),
    .bus_oe    (bus_oe),
    .bus_out   (bus_out),
    .drdy_n    (drdy_n),
    .pin_oe    (pin_oe),
    .seq_busy  (seq_busy),
    .stby_now  (stby_now),
    .smode_now (smode_now)
);

// File: tb/tb_conv_host_if.sv
`timescale 1ns/100ps
module tb_conv_host_if;
    localparam int DW    = 12;
    localparam int CAL   = 40;
    localparam int SYNCL = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [DW-1:0] bus_in = '0;
    logic [DW-1:0] bus_out;
    logic bus_oe, pin_out, pin_oe, drdy_n;
    logic pin_in = 1'b1;
    logic smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    conv_host_if #(.DW(DW), .CAL_CYCLES(CAL), .SYNC_CYCLES(SYNCL)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .smp_valid(smp_valid), .smp_data(smp_data), .drdy_n(drdy_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [DW-1:0] val, input bit sel);
        @(negedge clk);
        cs_n = ~sel; bus_in = val; wr_n = 1'b0;
        cyc(3);
        wr_n = 1'b1;
        cyc(5);
        cs_n = 1'b1;
    endtask

    task automatic host_read(output logic [DW-1:0] v);
        cs_n = 1'b0; rd_n = 1'b0;
        #0.5;
        check(bus_oe == 1'b1, "R2 oe during read", bus_oe, 1);
        v = bus_out;
        rd_n = 1'b1; cs_n = 1'b1;
        #0.5;
    endtask

    // one-cycle sample; returns at the negedge right after the capturing edge
    task automatic send(input logic [DW-1:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    function automatic logic [DW-1:0] uni(input logic [DW-1:0] d);
        return d ^ 12'h800;
    endfunction

    task automatic t_reset();
        check(drdy_n == 1'b1, "R1 drdy_n", drdy_n, 1);
        check(bus_oe == 1'b0, "R1 bus_oe", bus_oe, 0);
        check(pin_oe == 1'b1, "R1 pin_oe", pin_oe, 1);
        check(pin_out == 1'b0, "R1 pin_out", pin_out, 0);
    endtask

    task automatic t_read_gate();
        cs_n = 1'b0; rd_n = 1'b1; #0.5;
        check(bus_oe == 1'b0, "R2 rd high", bus_oe, 0);
        cs_n = 1'b1; rd_n = 1'b0; #0.5;
        check(bus_oe == 1'b0, "R2 cs high", bus_oe, 0);
        rd_n = 1'b1;
    endtask

    task automatic t_unipolar_ready();
        logic [DW-1:0] v;
        send(12'h123);
        check(drdy_n == 1'b1, "R5 high on update", drdy_n, 1);
        cyc(1);
        check(drdy_n == 1'b0, "R5 falls next clock", drdy_n, 0);
        check(pin_out == 1'b1, "R8 data valid", pin_out, 1);
        host_read(v);
        check(v == uni(12'h123), "R4 unipolar", v, uni(12'h123));
        send(12'hFFF);
        cyc(1);
        host_read(v);
        check(v == uni(12'hFFF), "R4 unipolar full", v, uni(12'hFFF));
    endtask

    task automatic t_bipolar();
        logic [DW-1:0] v;
        host_write(12'h004, 1'b1);
        send(12'h123);
        cyc(1);
        host_read(v);
        check(v == 12'h123, "R4 bipolar", v, 12'h123);
        host_write(12'h000, 1'b1);
    endtask

    task automatic t_write_unselected();
        logic [DW-1:0] v;
        host_write(12'h001, 1'b0);
        send(12'h0A5);
        cyc(1);
        check(drdy_n == 1'b0, "R3 unselected write ignored", drdy_n, 0);
        host_read(v);
        check(v == uni(12'h0A5), "R3 sample accepted", v, uni(12'h0A5));
    endtask

    task automatic t_standby();
        logic [DW-1:0] v;
        host_write(12'h001, 1'b1);
        check(drdy_n == 1'b1, "R6 drdy in standby", drdy_n, 1);
        send(12'h777);
        cyc(2);
        check(drdy_n == 1'b1, "R6 drdy held", drdy_n, 1);
        host_read(v);
        check(v == uni(12'h0A5), "R6 sample ignored", v, uni(12'h0A5));
        host_write(12'h000, 1'b1);
        send(12'h321);
        cyc(1);
        check(drdy_n == 1'b0, "R6 resumes", drdy_n, 0);
    endtask

    task automatic t_testbit();
        logic [DW-1:0] v;
        host_write(12'h200, 1'b1);
        send(12'h456);
        cyc(1);
        check(drdy_n == 1'b1, "R10 drdy held", drdy_n, 1);
        host_read(v);
        check(v == uni(12'h321), "R10 sample ignored", v, uni(12'h321));
        host_write(12'h000, 1'b1);
    endtask

    task automatic t_cal();
        logic [DW-1:0] v;
        host_write(12'h002, 1'b1);
        check(drdy_n == 1'b1, "R7 drdy at cal", drdy_n, 1);
        check(pin_out == 1'b0, "R8 valid cleared by cal", pin_out, 0);
        cyc(CAL / 2);
        send(12'h111);
        cyc(1);
        check(drdy_n == 1'b1, "R7 drdy mid cal", drdy_n, 1);
        host_read(v);
        check(v == uni(12'h321), "R7 sample ignored in cal", v, uni(12'h321));
        cyc(CAL);
        send(12'h222);
        cyc(1);
        check(drdy_n == 1'b0, "R7 cal ended", drdy_n, 0);
        host_read(v);
        check(v == uni(12'h222), "R7 accepted after", v, uni(12'h222));
        cyc(CAL);
        check(drdy_n == 1'b0, "R7 no restart", drdy_n, 0);
    endtask

    task automatic t_collision();
        logic [DW-1:0] v;
        @(negedge clk);
        cs_n = 1'b0; bus_in = 12'h002; wr_n = 1'b0;
        cyc(3);
        wr_n = 1'b1;
        cyc(2);
        smp_valid = 1'b1; smp_data = 12'h5A5;
        cyc(1);
        smp_valid = 1'b0;
        check(drdy_n == 1'b1, "R11 drdy at start", drdy_n, 1);
        cyc(3);
        cs_n = 1'b1;
        host_read(v);
        check(v == uni(12'h222), "R11 colliding sample dropped", v, uni(12'h222));
        cyc(CAL + 4);
        check(drdy_n == 1'b1, "R11 no stale ready", drdy_n, 1);
        send(12'h333);
        cyc(1);
        host_read(v);
        check(v == uni(12'h333), "R11 next accepted", v, uni(12'h333));
    endtask

    task automatic t_sync();
        logic [DW-1:0] v;
        // data-valid mode: pin edges have no effect
        @(negedge clk); pin_in = 1'b0;
        cyc(3); pin_in = 1'b1;
        cyc(5);
        check(drdy_n == 1'b0, "R9 edge ignored in dval mode", drdy_n, 0);
        check(pin_out == 1'b1, "R8 pin_out valid", pin_out, 1);
        host_write(12'h008, 1'b1);
        check(pin_oe == 1'b0, "R8 pin released", pin_oe, 0);
        send(12'h444);
        cyc(1);
        check(drdy_n == 1'b0, "R9 sync mode keeps data path", drdy_n, 0);
        pin_in = 1'b0;
        cyc(3); pin_in = 1'b1;
        cyc(4);
        check(drdy_n == 1'b1, "R9 sync started", drdy_n, 1);
        cyc(SYNCL / 3);
        send(12'h555);
        cyc(1);
        host_read(v);
        check(v == uni(12'h444), "R9 sample ignored in sync", v, uni(12'h444));
        cyc(SYNCL);
        send(12'h666);
        cyc(1);
        check(drdy_n == 1'b0, "R9 sync ended", drdy_n, 0);
        host_read(v);
        check(v == uni(12'h666), "R9 accepted after", v, uni(12'h666));
        host_write(12'h000, 1'b1);
        check(pin_oe == 1'b1, "R8 pin driven again", pin_oe, 1);
    endtask

    initial begin
        cyc(3);
        #0.5;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_read_gate();
        t_unipolar_ready();
        t_bipolar();
        t_write_unselected();
        t_standby();
        t_testbit();
        t_cal();
        t_collision();
        t_sync();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule